// File: doc/BRIEF.md
# Serial Row/Column Address Receiver

This block takes array addresses that arrive one bit at a time on a single data pin. It converts each one into a parallel word. Each word is 8 bits long and is sent most significant bit first. A start strobe marks the first bit of a word, and a word-type select says whether the word is a row address or a column address. A row word that passes the range check is latched and held as the current row.

A column word is made of two parts. The upper two bits select an operation: a write from the input shift register, a read into output register A, a read into output register B, or a refresh. The lower six bits select the column. When a column word completes while a valid row is held, the block issues a one-cycle command strobe. The strobe carries the row, the column, the raw mode field and a one-hot operation decode to the array controller.

Top module: `serial_addr_rx`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, row_vld_o, row_err_o, cmd_vld_o and cmd_op_o are 0, and row_o, cmd_row_o, cmd_col_o and cmd_mode_o are 0.
- R2: A bit is accepted only in a cycle with bit_vld_i high. Words are shifted in MSB first. A word is complete on its 8th accepted bit, and any number of idle cycles may separate its bits.
- R3: start_i, asserted together with bit_vld_i, discards any partial word and begins a new one. The bit in that cycle is the new word's MSB, and word_col_i in that cycle sets the word type (0 = row, 1 = column).
- R4: When a row word whose value is below ROW_LIMIT (212) completes, then from the cycle after its last bit row_o equals that value and row_vld_o is high. Both hold until the next row word completes.
- R5: When a row word of value ROW_LIMIT or above completes, row_err_o pulses high for exactly the one cycle after its last bit. row_vld_o goes low, and row_o keeps its previous value.
- R6: When a column word completes while row_vld_o is high, cmd_vld_o pulses for exactly the one cycle after its last bit. In that cycle cmd_row_o equals row_o, cmd_col_o equals word bits [5:0], and cmd_mode_o equals word bits [7:6].
- R7: cmd_op_o is one-hot while cmd_vld_o is high: mode 00 (write from input) gives 0001, 01 (read to A) gives 0010, 10 (read to B) gives 0100, and 11 (refresh) gives 1000. It is 0000 in every other cycle.
- R8: A column word that completes while row_vld_o is low issues no command, and cmd_row_o, cmd_col_o and cmd_mode_o keep their values. These three outputs change only in a cycle where cmd_vld_o is high.
- R9: Bits accepted after a word has completed, with no new start_i, are ignored. They do not change row_o, row_vld_o or the command outputs, and they cause no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Address clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | First bit of a word |
| word_col_i | input | 1 | Word type at start: 0 row, 1 column |
| bit_vld_i | input | 1 | Serial bit present |
| sdat_i | input | 1 | Serial address bit |
| row_o | output | 8 | Latched row address |
| row_vld_o | output | 1 | Latched row is in range |
| row_err_o | output | 1 | Out-of-range row pulse |
| cmd_vld_o | output | 1 | Command pulse |
| cmd_row_o | output | 8 | Row of the command |
| cmd_col_o | output | 6 | Column of the command |
| cmd_mode_o | output | 2 | Raw mode field of the command |
| cmd_op_o | output | 4 | One-hot operation decode |

## Verification
The bench builds the block with its default parameters: 8-bit words, a 2-bit mode field and a row limit of 212. With these values every word value is small enough to sweep exhaustively. All 256 row values are sent, so the boundary at 211/212 and the saturation at 255 are both covered. Each in-range row is followed by a column word that cycles through all four modes. A second pass sends all 256 column values against one held row. Interleaved cases cover idle gaps between bits, restart in mid-word, trailing bits after completion, and column words sent with no valid row.

// File: rtl/serial_addr_rx_pkg.sv
package serial_addr_rx_pkg;
  typedef enum logic [1:0] {
    MODE_WR_IN  = 2'd0,
    MODE_RD_A   = 2'd1,
    MODE_RD_B   = 2'd2,
    MODE_REFR   = 2'd3
  } sar_mode_e;
endpackage

// File: rtl/sar_shifter.sv
module sar_shifter #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          word_col_i,
  input  logic          bit_vld_i,
  input  logic          sdat_i,
  output logic          done_o,
  output logic          done_col_o,
  output logic [AW-1:0] word_o
);
  localparam int CW = (AW > 1) ? $clog2(AW) : 1;
  localparam logic [CW-1:0] LAST = CW'(AW - 1);

  logic [CW-1:0] cnt_q, cnt_eff;
  logic [AW-1:0] sh_q, sh_eff, sh_nxt;
  logic          act_q, act_eff, col_q, col_eff;

  // start_i restarts the word in the same cycle
  always_comb begin
    cnt_eff = start_i ? '0 : cnt_q;
    sh_eff  = start_i ? '0 : sh_q;
    act_eff = start_i | act_q;
    col_eff = start_i ? word_col_i : col_q;
    sh_nxt  = {sh_eff[AW-2:0], sdat_i};
  end

  assign done_o     = bit_vld_i & act_eff & (cnt_eff == LAST);
  assign done_col_o = col_eff;
  assign word_o     = sh_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
      act_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      col_q <= col_eff;
      if (bit_vld_i && act_eff) begin
        sh_q <= sh_nxt;
        if (cnt_eff == LAST) begin
          cnt_q <= '0;
          act_q <= 1'b0;
        end else begin
          cnt_q <= cnt_eff + CW'(1);
          act_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_eff;
        sh_q  <= sh_eff;
        act_q <= act_eff;
      end
    end
  end
endmodule

// File: rtl/sar_row_latch.sv
module sar_row_latch #(
  parameter int AW        = 8,
  parameter int ROW_LIMIT = 212
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic          done_col_i,
  input  logic [AW-1:0] word_i,
  output logic [AW-1:0] row_o,
  output logic          row_vld_o,
  output logic          row_err_o
);
  localparam logic [AW:0] LIM = (AW+1)'(ROW_LIMIT);

  logic row_done, in_range;
  assign row_done = done_i & ~done_col_i;
  assign in_range = {1'b0, word_i} < LIM;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o     <= '0;
      row_vld_o <= 1'b0;
      row_err_o <= 1'b0;
    end else begin
      row_err_o <= row_done & ~in_range;
      if (row_done) begin
        row_vld_o <= in_range;
        if (in_range) row_o <= word_i;
      end
    end
  end
endmodule

// File: rtl/sar_cmd_gen.sv
module sar_cmd_gen #(
  parameter int AW     = 8,
  parameter int MODE_W = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 done_i,
  input  logic                 done_col_i,
  input  logic [AW-1:0]        word_i,
  input  logic [AW-1:0]        row_i,
  input  logic                 row_vld_i,
  output logic                 cmd_vld_o,
  output logic [AW-1:0]        cmd_row_o,
  output logic [AW-MODE_W-1:0] cmd_col_o,
  output logic [MODE_W-1:0]    cmd_mode_o,
  output logic [2**MODE_W-1:0] cmd_op_o
);
  localparam int COL_W = AW - MODE_W;
  localparam int N_OP  = 2**MODE_W;

  logic              fire;
  logic [MODE_W-1:0] mode_w;
  logic [N_OP-1:0]   op_w;

  assign fire   = done_i & done_col_i & row_vld_i;
  assign mode_w = word_i[AW-1 -: MODE_W];

  for (genvar g = 0; g < N_OP; g++) begin : g_op
    assign op_w[g] = (mode_w == MODE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_vld_o  <= 1'b0;
      cmd_row_o  <= '0;
      cmd_col_o  <= '0;
      cmd_mode_o <= '0;
      cmd_op_o   <= '0;
    end else begin
      cmd_vld_o <= fire;
      cmd_op_o  <= fire ? op_w : '0;
      if (fire) begin
        cmd_row_o  <= row_i;
        cmd_col_o  <= word_i[COL_W-1:0];
        cmd_mode_o <= mode_w;
      end
    end
  end
endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx
  import serial_addr_rx_pkg::*;
#(
  parameter int AW        = 8,
  parameter int MODE_W    = 2,
  parameter int ROW_LIMIT = 212
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 word_col_i,
  input  logic                 bit_vld_i,
  input  logic                 sdat_i,
  output logic [AW-1:0]        row_o,
  output logic                 row_vld_o,
  output logic                 row_err_o,
  output logic                 cmd_vld_o,
  output logic [AW-1:0]        cmd_row_o,
  output logic [AW-MODE_W-1:0] cmd_col_o,
  output logic [MODE_W-1:0]    cmd_mode_o,
  output logic [2**MODE_W-1:0] cmd_op_o
);
  logic          done, done_col;
  logic [AW-1:0] word;

  sar_shifter #(.AW(AW)) i_shift (
    .clk_i, .rst_ni, .start_i, .word_col_i, .bit_vld_i, .sdat_i,
    .done_o(done), .done_col_o(done_col), .word_o(word)
  );

  sar_row_latch #(.AW(AW), .ROW_LIMIT(ROW_LIMIT)) i_row (
    .clk_i, .rst_ni, .done_i(done), .done_col_i(done_col), .word_i(word),
    .row_o, .row_vld_o, .row_err_o
  );

  sar_cmd_gen #(.AW(AW), .MODE_W(MODE_W)) i_cmd (
    .clk_i, .rst_ni, .done_i(done), .done_col_i(done_col), .word_i(word),
    .row_i(row_o), .row_vld_i(row_vld_o),
    .cmd_vld_o, .cmd_row_o, .cmd_col_o, .cmd_mode_o, .cmd_op_o
  );
endmodule

// File: rtl/serial_addr_rx_chk.sv
module serial_addr_rx_chk #(
  parameter int AW        = 8,
  parameter int MODE_W    = 2,
  parameter int ROW_LIMIT = 212
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [AW-1:0]        row_o,
  input logic                 row_vld_o,
  input logic                 row_err_o,
  input logic                 cmd_vld_o,
  input logic [AW-1:0]        cmd_row_o,
  input logic [AW-MODE_W-1:0] cmd_col_o,
  input logic [MODE_W-1:0]    cmd_mode_o,
  input logic [2**MODE_W-1:0] cmd_op_o
);
  assert_row_in_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_vld_o |-> ({1'b0, row_o} < (AW+1)'(ROW_LIMIT)));
  assert_err_clears_vld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_err_o |-> !row_vld_o);
  assert_err_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_err_o |=> !row_err_o);
  assert_cmd_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |=> !cmd_vld_o);
  assert_cmd_row_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> (row_vld_o && cmd_row_o == row_o));
  assert_op_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> ($countones(cmd_op_o) == 1 && cmd_op_o[cmd_mode_o]));
  assert_op_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_o |-> (cmd_op_o == '0));
  assert_fields_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_vld_o |=> (cmd_vld_o || ($stable(cmd_col_o) && $stable(cmd_mode_o)
                                  && $stable(cmd_row_o))));
endmodule

bind serial_addr_rx serial_addr_rx_chk #(.AW(AW), .MODE_W(MODE_W), .ROW_LIMIT(ROW_LIMIT)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .row_o(row_o), .row_vld_o(row_vld_o),
  .row_err_o(row_err_o), .cmd_vld_o(cmd_vld_o), .cmd_row_o(cmd_row_o),
  .cmd_col_o(cmd_col_o), .cmd_mode_o(cmd_mode_o), .cmd_op_o(cmd_op_o)
);

// File: tb/test_serial_addr_rx.sv
module test_serial_addr_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wcol = 1'b0, bvld = 1'b0, sdat = 1'b0;
  logic [7:0] row;
  logic       row_vld, row_err, cmd_vld;
  logic [7:0] cmd_row;
  logic [5:0] cmd_col;
  logic [1:0] cmd_mode;
  logic [3:0] cmd_op;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // expected model
  logic [7:0] e_row = '0;
  logic       e_vld = 1'b0;
  logic [7:0] e_crow = '0;
  logic [5:0] e_col = '0;
  logic [1:0] e_mode = '0;

  always #4 clk = ~clk;

  serial_addr_rx i_serial_addr_rx (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .word_col_i(wcol),
    .bit_vld_i(bvld), .sdat_i(sdat), .row_o(row), .row_vld_o(row_vld),
    .row_err_o(row_err), .cmd_vld_o(cmd_vld), .cmd_row_o(cmd_row),
    .cmd_col_o(cmd_col), .cmd_mode_o(cmd_mode), .cmd_op_o(cmd_op)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drives a word; returns at the negedge after the last bit's edge
  task automatic send_word(input logic is_col, input logic [7:0] v, input int gap);
    @(negedge clk);
    start = 1'b1; wcol = is_col; bvld = 1'b1; sdat = v[7];
    for (int i = 6; i >= 0; i--) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        start = 1'b0; bvld = 1'b0; sdat = ~sdat; wcol = ~is_col;
      end
      @(negedge clk);
      start = 1'b0; bvld = 1'b1; sdat = v[i]; wcol = ~is_col;
    end
    @(negedge clk);
    bvld = 1'b0; sdat = 1'b0;
  endtask

  task automatic expect_row(input logic [7:0] v, input string tag);
    logic ok = (v < 8'd212);
    if (ok) begin e_row = v; e_vld = 1'b1; end
    else e_vld = 1'b0;
    chk({tag, " row_vld"}, 32'(row_vld), 32'(e_vld));
    chk({tag, " row_o"}, 32'(row), 32'(e_row));
    chk({tag, " row_err"}, 32'(row_err), 32'(!ok));
  endtask

  task automatic expect_col(input logic [7:0] v, input string tag);
    if (e_vld) begin
      e_crow = e_row; e_col = v[5:0]; e_mode = v[7:6];
    end
    chk({tag, " cmd_vld"}, 32'(cmd_vld), 32'(e_vld));
    chk({tag, " cmd_op"}, 32'(cmd_op), e_vld ? 32'(4'b0001 << v[7:6]) : 32'd0);
    chk({tag, " cmd_fields"}, {16'(cmd_row), 8'(cmd_col), 8'(cmd_mode)},
        {16'(e_crow), 8'(e_col), 8'(e_mode)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {row, 8'(row_vld), 8'(row_err), 8'(cmd_vld)}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {cmd_row, 2'b0, cmd_col, 6'b0, cmd_mode, cmd_op}, 32'd0);

    // R8: column before any row
    send_word(1'b1, 8'hC5, 0);
    expect_col(8'hC5, "R8 no row");

    // R4 R5 R6 R7 R2: all row values, gaps vary
    for (int r = 0; r < 256; r++) begin
      logic [7:0] c = 8'((r * 37 + 5) & 255);
      send_word(1'b0, 8'(r), r % 3);
      expect_row(8'(r), (r < 212) ? "R4" : "R5");
      @(negedge clk);
      chk("R5 err single cycle", 32'(row_err), 32'd0);
      send_word(1'b1, c, (r + 1) % 2);
      expect_col(c, e_vld ? "R6 R7 R2" : "R8");
      @(negedge clk);
      chk("R6 pulse single cycle", {28'(cmd_vld), cmd_op}, 32'd0);
    end

    // all column values against one held row
    send_word(1'b0, 8'd100, 0);
    expect_row(8'd100, "R4");
    for (int c = 0; c < 256; c++) begin
      send_word(1'b1, 8'(c), 0);
      expect_col(8'(c), "R6 R7 sweep");
    end

    // R3: restart mid-word
    @(negedge clk);
    start = 1'b1; wcol = 1'b0; bvld = 1'b1; sdat = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); start = 1'b0; sdat = 1'b1;
    end
    bvld = 1'b0;
    send_word(1'b0, 8'd7, 0);
    expect_row(8'd7, "R3 restart");
    // R3: column word restarted as row word
    @(negedge clk);
    start = 1'b1; wcol = 1'b1; bvld = 1'b1; sdat = 1'b0;
    @(negedge clk); start = 1'b0; bvld = 1'b0;
    send_word(1'b0, 8'd211, 1);
    expect_row(8'd211, "R3 type reselect");
    chk("R3 no cmd", 32'(cmd_vld), 32'd0);

    // R9: trailing bits ignored
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      bvld = 1'b1; sdat = 1'b1;
      chk("R9 trailing row_o", {row, 8'(row_vld), 8'(row_err), 8'(cmd_vld)},
          {8'd211, 8'd1, 8'd0, 8'd0});
    end
    @(negedge clk); bvld = 1'b0;
    chk("R9 trailing end", {row, 8'(row_vld), 8'(row_err), 8'(cmd_vld)},
        {8'd211, 8'd1, 8'd0, 8'd0});
    send_word(1'b1, 8'hBF, 0);
    expect_col(8'hBF, "R9 next cmd");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule